// File: doc/BRIEF.md
# Trigger Multiplexer Output Channel

This block forms one output of a trigger routing fabric. A single 32-bit control word, loaded through a plain write-enable register port, chooses which of the incoming trigger lines feeds the output. It also decides how that line is conditioned on the way to the consumer. The chosen line can be inverted. It can then either pass straight through as a level, or be brought into the consumer clock domain and reshaped into a fixed-width pulse, one pulse for each rising edge.

Line 0 is wired to a constant low inside the block. Software-driven channels therefore park on selector 0, and a hardware line can never fire them. A debug-freeze input, armed by a control bit, silences the output while the system is halted for debugging.

Both clock domains take an asynchronous active-low reset. Inside the block each reset is released through a two-flop synchronizer, so the block leaves reset two clock edges after its reset input goes high.

Top module: `trig_mux_chan`

## Requirements
- R1: After reset the control word reads 0x00000000. This selects line 0, with no inversion, level mode and freeze disarmed, and `trig_out` stays low.
- R2: Field layout of the control word: selector in bits [7:0], invert in bit 8, edge mode in bit 9, freeze arm in bit 12. A write takes effect at the clock edge on which `cfg_we` is high. All other bits read back 0 whatever was written, so writing 0xFFFFFFFF reads back 0x000013FF.
- R3: Selector value k in 1..N_IN-1 routes `trig_in[k]` to the output. Selector 0 routes a constant 0, even when every input line is high.
- R4: A selector value of N_IN or above routes a constant 0.
- R5: With the invert bit set, the selected line is complemented before the level/edge stage.
- R6: In level mode (bit 9 clear), `trig_out` follows the conditioned line combinationally, with no clock delay.
- R7: In edge mode, a rising edge of the conditioned line is captured by two consumer-clock flops and then detected. `trig_out` rises on the third consumer edge after the input rises and stays high for exactly PULSE_CYC (2) consumer cycles. An input that stays high produces only one pulse.
- R8: A rising edge detected while a pulse is still active neither restarts nor extends that pulse.
- R9: When the freeze arm bit is set and `dbg_freeze` is high, `trig_out` is forced low in both modes, and the output returns as soon as `dbg_freeze` falls. When the arm bit is clear, `dbg_freeze` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, register domain |
| cfg_we | input | 1 | Write enable for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word, reserved bits zero |
| trig_in | input | N_IN-1 (15), indices N_IN-1..1 | Input trigger lines 1 to N_IN-1 |
| dbg_freeze | input | 1 | Debug halt indication |
| cons_clk | input | 1 | Consumer clock |
| cons_rst_n | input | 1 | Asynchronous active-low reset, consumer domain |
| trig_out | output | 1 | Conditioned output trigger |

## Verification
Two functions can act in the same cycle. The first case is a freeze request that lands while an edge-mode pulse is in flight: the bench raises `dbg_freeze` in the first cycle of the pulse and drops it in the second. The output must go low for that first cycle only, come back for the second, and end on schedule, because the freeze gates the pulse without stalling its counter. The second case is a fresh edge detected during the last cycle of a pulse: the bench feeds a high-low-high pattern, and the output must fall after exactly two cycles instead of being reloaded.

// File: rtl/trig_mux_pkg.sv
`timescale 1ns/1ps
package trig_mux_pkg;

  localparam int unsigned CFG_W    = 32;
  localparam int unsigned SEL_W    = 8;
  localparam int unsigned SEL_LSB  = 0;
  localparam int unsigned INV_BIT  = 8;
  localparam int unsigned EDGE_BIT = 9;
  localparam int unsigned FRZ_BIT  = 12;

  localparam logic [CFG_W-1:0] CFG_MASK =
    (CFG_W'(1) << FRZ_BIT) | (CFG_W'(1) << EDGE_BIT) |
    (CFG_W'(1) << INV_BIT) | (((CFG_W'(1) << SEL_W) - 1) << SEL_LSB);

  typedef struct packed {
    logic             frz_en;
    logic             edge_en;
    logic             inv_en;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;

endpackage

// File: rtl/trig_rst_sync.sv
`timescale 1ns/1ps
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/trig_cfg_reg.sv
`timescale 1ns/1ps
module trig_cfg_reg
  import trig_mux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output chan_cfg_t        cfg,
  output logic [CFG_W-1:0] rdata
);
  chan_cfg_t cfg_q;
  chan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.sel     = wdata[SEL_LSB +: SEL_W];
      cfg_d.inv_en  = wdata[INV_BIT];
      cfg_d.edge_en = wdata[EDGE_BIT];
      cfg_d.frz_en  = wdata[FRZ_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata                     = '0;
    rdata[SEL_LSB +: SEL_W]   = cfg_q.sel;
    rdata[INV_BIT]            = cfg_q.inv_en;
    rdata[EDGE_BIT]           = cfg_q.edge_en;
    rdata[FRZ_BIT]            = cfg_q.frz_en;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/trig_line_sel.sv
`timescale 1ns/1ps
module trig_line_sel
  import trig_mux_pkg::*;
#(
  parameter int unsigned N_IN = 16
) (
  input  logic [N_IN-1:1]  lines,
  input  logic [SEL_W-1:0] sel,
  output logic             picked
);
  logic [N_IN-1:0] hit;

  assign hit[0] = 1'b0;

  for (genvar gi = 1; gi < N_IN; gi++) begin : g_hit
    assign hit[gi] = (sel == SEL_W'(gi)) & lines[gi];
  end

  assign picked = |hit;
endmodule

// File: rtl/trig_edge_pulse.sv
`timescale 1ns/1ps
module trig_edge_pulse #(
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

  logic [SYNC_STG:0] sync_q;
  logic [SYNC_STG:0] sync_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              rise;
  logic              busy;

  assign rise = sync_q[SYNC_STG-1] & ~sync_q[SYNC_STG];
  assign busy = (cnt_q != '0);

  always_comb begin
    sync_d = {sync_q[SYNC_STG-1:0], async_in};
    cnt_d  = cnt_q;
    if (busy)      cnt_d = cnt_q - CNT_W'(1);
    else if (rise) cnt_d = CNT_W'(PULSE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pulse = busy;
endmodule

// File: rtl/trig_mux_chan.sv
`timescale 1ns/1ps
module trig_mux_chan
  import trig_mux_pkg::*;
#(
  parameter int unsigned N_IN      = 16,
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [N_IN-1:1]  trig_in,
  input  logic             dbg_freeze,
  input  logic             cons_clk,
  input  logic             cons_rst_n,
  output logic             trig_out
);
  logic      src_rst_n;
  logic      dst_rst_n;
  chan_cfg_t cfg;
  logic      picked;
  logic      cond;
  logic      edge_pulse;
  logic      shaped;
  logic      frozen;

  trig_rst_sync #(.STAGES(2)) u_src_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(src_rst_n)
  );

  trig_rst_sync #(.STAGES(2)) u_dst_rst (
    .clk(cons_clk), .arst_n(cons_rst_n), .rst_n_sync(dst_rst_n)
  );

  trig_cfg_reg u_reg (
    .clk(clk), .rst_n(src_rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  trig_line_sel #(.N_IN(N_IN)) u_sel (
    .lines(trig_in), .sel(cfg.sel), .picked(picked)
  );

  assign cond = picked ^ cfg.inv_en;

  trig_edge_pulse #(.PULSE_CYC(PULSE_CYC), .SYNC_STG(2)) u_pulse (
    .clk(cons_clk), .rst_n(dst_rst_n), .async_in(cond), .pulse(edge_pulse)
  );

  assign shaped   = cfg.edge_en ? edge_pulse : cond;
  assign frozen   = cfg.frz_en & dbg_freeze;
  assign trig_out = shaped & ~frozen;
endmodule

// File: rtl/trig_mux_chan_chk.sv
`timescale 1ns/1ps
module trig_mux_chan_chk
  import trig_mux_pkg::*;
(
  input logic             clk,
  input logic             cons_clk,
  input logic             src_rst_n,
  input logic             dst_rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             dbg_freeze,
  input logic             edge_pulse,
  input logic             trig_out
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!src_rst_n)
    (cfg_rdata & ~CFG_MASK) == '0);                                    // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!src_rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_MASK));            // R2

  AST_SEL0_QUIET: assert property (@(posedge cons_clk) disable iff (!dst_rst_n)
    (cfg_rdata[SEL_LSB +: SEL_W] == '0 && !cfg_rdata[INV_BIT] &&
     !cfg_rdata[EDGE_BIT]) |-> !trig_out);                             // R3

  AST_FREEZE_BLOCK: assert property (@(posedge cons_clk) disable iff (!dst_rst_n)
    (cfg_rdata[FRZ_BIT] && dbg_freeze) |-> !trig_out);                 // R9

  AST_PULSE_HOLD: assert property (@(posedge cons_clk) disable iff (!dst_rst_n)
    $rose(edge_pulse) |=> edge_pulse);                                 // R7

  AST_PULSE_END: assert property (@(posedge cons_clk) disable iff (!dst_rst_n)
    (edge_pulse && $past(edge_pulse)) |=> !edge_pulse);                // R8
endmodule

bind trig_mux_chan trig_mux_chan_chk u_chk (
  .clk(clk), .cons_clk(cons_clk), .src_rst_n(src_rst_n), .dst_rst_n(dst_rst_n),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .dbg_freeze(dbg_freeze), .edge_pulse(edge_pulse), .trig_out(trig_out)
);

// File: tb/trig_mux_chan_tb.sv
`timescale 1ns/1ps
module trig_mux_chan_tb;
  localparam int N_IN = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [N_IN-1:1] trig_in;
  logic        dbg_freeze;
  logic        trig_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  trig_mux_chan #(.N_IN(N_IN), .PULSE_CYC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig_in(trig_in), .dbg_freeze(dbg_freeze),
    .cons_clk(clk), .cons_rst_n(rst_n), .trig_out(trig_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    #1;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, 32'h0);
    trig_in = '1; #1;
    chk("R1 out", {31'b0, trig_out}, 32'h0);
    trig_in = '0;
  endtask

  task automatic t_regs();
    wr(32'hFFFF_FFFF);
    chk("R2 all-ones", cfg_rdata, 32'h0000_13FF);
    wr(32'hABCD_0A5C);
    chk("R2 mixed", cfg_rdata, 32'h0000_025C);
    wr(32'h0);
  endtask

  task automatic t_select();
    wr(32'd5);
    trig_in = '0; trig_in[5] = 1'b1; #1;
    chk("R3 sel5 hi", {31'b0, trig_out}, 32'h1);
    trig_in = '1; trig_in[5] = 1'b0; #1;
    chk("R3 sel5 lo", {31'b0, trig_out}, 32'h0);
    wr(32'd15);
    trig_in = '0; trig_in[15] = 1'b1; #1;
    chk("R3 sel15", {31'b0, trig_out}, 32'h1);
    wr(32'd0);
    trig_in = '1; step();
    chk("R3 sel0", {31'b0, trig_out}, 32'h0);
    wr(32'd200);
    step();
    chk("R4 sel200", {31'b0, trig_out}, 32'h0);
    wr(32'd16);
    chk("R4 sel16", {31'b0, trig_out}, 32'h0);
    trig_in = '0;
  endtask

  task automatic t_level_inv();
    wr(32'h0000_0107);
    trig_in = '0; #1;
    chk("R5 inv lo-in", {31'b0, trig_out}, 32'h1);
    trig_in[7] = 1'b1; #1;
    chk("R5 inv hi-in", {31'b0, trig_out}, 32'h0);
    wr(32'd7);
    chk("R6 level hi", {31'b0, trig_out}, 32'h1);
    #2; trig_in[7] = 1'b0; #1;
    chk("R6 level comb", {31'b0, trig_out}, 32'h0);
  endtask

  task automatic t_edge();
    logic [5:0] exp = 6'b001100;
    trig_in = '0;
    wr(32'h0000_0203);
    repeat (4) step();
    @(negedge clk); trig_in[3] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk($sformatf("R7 edge cyc%0d", i + 1), {31'b0, trig_out}, {31'b0, exp[5-i]});
    end
    trig_in[3] = 1'b0;
    repeat (4) step();
  endtask

  task automatic t_retrig();
    logic [3:0] exp = 4'b1100;
    trig_in = '0;
    wr(32'h0000_0204);
    repeat (4) step();
    @(negedge clk); trig_in[4] = 1'b1;
    @(negedge clk); trig_in[4] = 1'b0;
    @(negedge clk); trig_in[4] = 1'b1; #1;
    chk("R8 pre", {31'b0, trig_out}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk($sformatf("R8 retrig cyc%0d", i + 3), {31'b0, trig_out}, {31'b0, exp[3-i]});
    end
    trig_in = '0;
    repeat (4) step();
  endtask

  task automatic t_freeze();
    wr(32'h0000_1009);
    trig_in = '0; trig_in[9] = 1'b1; dbg_freeze = 1'b1; #1;
    chk("R9 level frozen", {31'b0, trig_out}, 32'h0);
    dbg_freeze = 1'b0; #1;
    chk("R9 level released", {31'b0, trig_out}, 32'h1);
    wr(32'd9);
    dbg_freeze = 1'b1; #1;
    chk("R9 unarmed", {31'b0, trig_out}, 32'h1);
    dbg_freeze = 1'b0;
    trig_in = '0;
    wr(32'h0000_1209);
    repeat (4) step();
    @(negedge clk); trig_in[9] = 1'b1;
    step(); step();
    @(negedge clk); dbg_freeze = 1'b1; #1;
    chk("R9 pulse frozen", {31'b0, trig_out}, 32'h0);
    @(negedge clk); dbg_freeze = 1'b0; #1;
    chk("R9 pulse resumes", {31'b0, trig_out}, 32'h1);
    step();
    chk("R9 pulse ends", {31'b0, trig_out}, 32'h0);
    trig_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; trig_in = '0; dbg_freeze = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_regs();
    t_select();
    t_level_inv();
    t_edge();
    t_retrig();
    t_freeze();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule